// File: doc/BRIEF.md
# Slave Communication State Machine

This block holds the communication state of a fieldbus slave device. The bus master asks for a new state by presenting a 4-bit state code with a one-cycle valid strobe. The block checks each request against a fixed set of permitted transitions. A permitted request is taken at the clock edge where it is presented. A forbidden request leaves the state as it was and raises a sticky error flag, which stays up until the local side acknowledges it.

The current state drives four enables. One admits mailbox traffic. One admits cyclic process-data exchange. One releases the physical outputs from their safe condition. The last one marks a firmware-download session. The outputs stay in their safe condition in every state except the fully operational one. The mailbox protocols themselves and the firmware storage sit outside this block.

Top module: `comm_state_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block enters state Init, err_flag is 0 and all four enables are 0.
- R2: State codes on cur_state and req_state are Init=4'd1, PreOp=4'd2, Boot=4'd3, SafeOp=4'd4 and Op=4'd8. A request is sampled at a rising edge where req_valid is 1, and an accepted request shows on cur_state right after that edge.
- R3: The permitted targets depend on the current state. From Init: Init, PreOp or Boot. From PreOp: Init, PreOp or SafeOp. From SafeOp or Op: Init, PreOp, SafeOp or Op. From Boot: Init or Boot only.
- R4: A request that is not permitted leaves cur_state unchanged and sets err_flag at the same edge. Requests for any code that is not a state code (0, 5-7, 9-15) are never permitted.
- R5: err_flag stays 1 until a rising edge where err_ack is 1 and no forbidden request is presented. If a forbidden request and err_ack arrive at the same edge, err_flag stays 1. err_ack has no effect while err_flag is 0.
- R6: While req_valid is 0, req_state has no effect on cur_state or err_flag.
- R7: mbx_en is 1 in PreOp, SafeOp, Op and Boot, and 0 in Init.
- R8: pd_en is 1 only in SafeOp and Op.
- R9: out_en is 1 only in Op.
- R10: fw_dl_en is 1 only in Boot.
- R11: A request for the current state is permitted: cur_state does not change and err_flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe from the master |
| req_state | input | 4 | Requested state code |
| err_ack | input | 1 | Clears the sticky error flag |
| cur_state | output | 4 | Current state code |
| err_flag | output | 1 | Sticky illegal-request flag |
| mbx_en | output | 1 | Mailbox traffic enable |
| pd_en | output | 1 | Process-data exchange enable |
| out_en | output | 1 | Physical outputs released from safe condition |
| fw_dl_en | output | 1 | Firmware-download session active |

## Verification
The hardest stimulus to produce from the ports is a forbidden request whose source state is deep in the chain, such as Op or Boot. Op can only be reached by walking through PreOp and SafeOp. So for every pair of source state and requested code, the bench resets the block, walks the permitted path to the source state, and then presents the request. That gives an exhaustive sweep of 5 states by 16 codes. A second corner is a forbidden request that meets an acknowledge at the same edge. The bench builds this directly, after first setting the error flag and then making a permitted move with the flag still up.

// File: rtl/comm_state_pkg.sv
// Package: shared state codes for the slave communication state machine.
// Assumes: a 4-bit state code; the Op and SafeOp codes are single bits.
package comm_state_pkg;
    localparam int STATE_W = 4;
    localparam logic [STATE_W-1:0] ST_INIT   = 4'd1;
    localparam logic [STATE_W-1:0] ST_PREOP  = 4'd2;
    localparam logic [STATE_W-1:0] ST_BOOT   = 4'd3;
    localparam logic [STATE_W-1:0] ST_SAFEOP = 4'd4;
    localparam logic [STATE_W-1:0] ST_OP     = 4'd8;

    // Enable bundle driven by the current state.
    typedef struct packed {
        logic mbx;
        logic pd;
        logic outp;
        logic fw;
    } comm_en_t;
endpackage

// File: rtl/comm_state_legal.sv
// Module: comm_state_legal
// Decides whether a requested state code is a permitted target from the
// current state. Purely combinational.
// Assumes: cur always holds one of the five state codes; an unknown cur
// permits only a return to Init.
module comm_state_legal
    import comm_state_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic [STATE_W-1:0] req,
    output logic               legal
);
    logic to_init, to_preop, to_boot, to_safeop, to_op;

    // Classify the requested code.
    always_comb begin
        to_init   = (req == ST_INIT);
        to_preop  = (req == ST_PREOP);
        to_boot   = (req == ST_BOOT);
        to_safeop = (req == ST_SAFEOP);
        to_op     = (req == ST_OP);
    end

    // Transition table keyed by the current state.
    always_comb begin
        case (cur)
            ST_INIT:   legal = to_init | to_preop | to_boot;
            ST_PREOP:  legal = to_init | to_preop | to_safeop;
            ST_BOOT:   legal = to_init | to_boot;
            ST_SAFEOP,
            ST_OP:     legal = to_init | to_preop | to_safeop | to_op;
            default:   legal = to_init;
        endcase
    end
endmodule

// File: rtl/comm_state_core.sv
// Module: comm_state_core
// Holds the state register and the sticky error flag.
// Assumes: legal is computed from the present state and req; a forbidden
// request takes priority over an acknowledge in the same cycle.
module comm_state_core
    import comm_state_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [STATE_W-1:0] req_state,
    input  logic               legal,
    input  logic               err_ack,
    output logic [STATE_W-1:0] state,
    output logic               err
);
    logic take, reject;

    // Split a valid request into accepted and rejected.
    always_comb begin
        take   = req_valid &  legal;
        reject = req_valid & ~legal;
    end

    // State register: load an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT;
        end else if (take) begin
            state <= req_state;
        end
    end

    // Error flag: set on rejection, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (reject) begin
            err <= 1'b1;
        end else if (err_ack) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/comm_state_gate.sv
// Module: comm_state_gate
// Decodes the current state into the traffic and output enables.
// Assumes: only Op releases the physical outputs.
module comm_state_gate
    import comm_state_pkg::*;
(
    input  logic [STATE_W-1:0] state,
    output comm_en_t           en
);
    // Per-state enable decode.
    always_comb begin
        en = '0;
        case (state)
            ST_PREOP:  en.mbx = 1'b1;
            ST_BOOT:   begin en.mbx = 1'b1; en.fw = 1'b1; end
            ST_SAFEOP: begin en.mbx = 1'b1; en.pd = 1'b1; end
            ST_OP:     begin en.mbx = 1'b1; en.pd = 1'b1; en.outp = 1'b1; end
            default:   en = '0;
        endcase
    end
endmodule

// File: rtl/comm_state_ctrl.sv
// Module: comm_state_ctrl (top)
// Slave communication state machine: checks master requests, tracks the
// state, flags forbidden requests and gates the traffic enables.
// Assumes: req_state is sampled only at edges where req_valid is 1.
module comm_state_ctrl
    import comm_state_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [STATE_W-1:0]     req_state,
    input  logic                   err_ack,
    output logic [STATE_W-1:0]     cur_state,
    output logic                   err_flag,
    output logic                   mbx_en,
    output logic                   pd_en,
    output logic                   out_en,
    output logic                   fw_dl_en
);
    logic               legal;
    logic [STATE_W-1:0] state;
    logic               err;
    comm_en_t           en;

    comm_state_legal i_legal (
        .cur   (state),
        .req   (req_state),
        .legal (legal)
    );

    comm_state_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_state (req_state),
        .legal     (legal),
        .err_ack   (err_ack),
        .state     (state),
        .err       (err)
    );

    comm_state_gate i_gate (
        .state (state),
        .en    (en)
    );

    // Drive the ports from the internal state and the enable bundle.
    always_comb begin
        cur_state = state;
        err_flag  = err;
        mbx_en    = en.mbx;
        pd_en     = en.pd;
        out_en    = en.outp;
        fw_dl_en  = en.fw;
    end
endmodule

// File: rtl/comm_state_ctrl_chk.sv
// Module: comm_state_ctrl_chk
// Checker bound to comm_state_ctrl. It relates the ports over time.
// Assumes: reset is held for at least two cycles.
module comm_state_ctrl_chk
    import comm_state_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [STATE_W-1:0] req_state,
    input logic               err_ack,
    input logic [STATE_W-1:0] cur_state,
    input logic               err_flag,
    input logic               mbx_en,
    input logic               pd_en,
    input logic               out_en,
    input logic               fw_dl_en
);
    // R1: the cycle after reset shows Init with no error
    a_r1_reset_init: assert property (@(posedge clk)
        !rst_n |=> (cur_state == ST_INIT && !err_flag));

    // R6: no request means no state change
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(cur_state));

    // R3: Op can only be entered from SafeOp or Op
    a_r3_op_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != ST_OP && cur_state != ST_SAFEOP) |=> cur_state != ST_OP);

    // R3: SafeOp can only be entered from PreOp, SafeOp or Op
    a_r3_safeop_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_INIT || cur_state == ST_BOOT) |=> cur_state != ST_SAFEOP);

    // R3: Boot leaves only to Init
    a_r3_boot_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_BOOT) |=> (cur_state == ST_BOOT || cur_state == ST_INIT));

    // R4: a new error comes only from a request that left the state unchanged
    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag ##1 err_flag) |-> ($past(req_valid) && $stable(cur_state)));

    // R5: the error flag holds without an acknowledge
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_ack) |=> err_flag);

    // R9, R8: released outputs imply process data, which implies mailbox
    a_r9_out_needs_pd: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (pd_en && mbx_en));
    a_r8_pd_needs_mbx: assert property (@(posedge clk) disable iff (!rst_n)
        pd_en |-> mbx_en);

    // R10: firmware download never overlaps process data
    a_r10_fw_alone: assert property (@(posedge clk) disable iff (!rst_n)
        fw_dl_en |-> (!pd_en && !out_en));
endmodule

bind comm_state_ctrl comm_state_ctrl_chk i_chk (.*);

// File: tb/test_comm_state_ctrl.sv
module test_comm_state_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_state = 4'd0;
    logic       err_ack = 1'b0;
    logic [3:0] cur_state;
    logic       err_flag, mbx_en, pd_en, out_en, fw_dl_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    comm_state_ctrl i_comm_state_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
        .err_ack(err_ack), .cur_state(cur_state), .err_flag(err_flag),
        .mbx_en(mbx_en), .pd_en(pd_en), .out_en(out_en), .fw_dl_en(fw_dl_en)
    );

    // Reference: is code t a permitted target from state f (R3, R4, R11)
    function automatic bit ref_ok(input logic [3:0] f, input logic [3:0] t);
        bit known = (t == 4'd1) || (t == 4'd2) || (t == 4'd3) || (t == 4'd4) || (t == 4'd8);
        if (!known) return 1'b0;
        if (t == 4'd1 || t == f) return 1'b1;
        if (f == 4'd1) return (t == 4'd2) || (t == 4'd3);
        if (f == 4'd2) return (t == 4'd4);
        if (f == 4'd4 || f == 4'd8) return (t != 4'd3);
        return 1'b0;
    endfunction

    // Reference enables {mbx, pd, out, fw} (R7..R10)
    function automatic logic [3:0] ref_en(input logic [3:0] s);
        logic m, p, o, w;
        m = (s == 4'd2) || (s == 4'd3) || (s == 4'd4) || (s == 4'd8);
        p = (s == 4'd4) || (s == 4'd8);
        o = (s == 4'd8);
        w = (s == 4'd3);
        return {m, p, o, w};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; err_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one request for one edge; returns after the following negedge
    task automatic request(input logic [3:0] code, input logic ack);
        req_valid = 1'b1; req_state = code; err_ack = ack;
        @(negedge clk);
        req_valid = 1'b0; err_ack = 1'b0;
    endtask

    task automatic pulse_ack();
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
    endtask

    // Walk the permitted path from Init to state s
    task automatic reach(input logic [3:0] s);
        if (s == 4'd3) request(4'd3, 1'b0);
        if (s == 4'd2 || s == 4'd4 || s == 4'd8) request(4'd2, 1'b0);
        if (s == 4'd4 || s == 4'd8) request(4'd4, 1'b0);
        if (s == 4'd8) request(4'd8, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] srcs [5] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd8};
        logic [3:0] exp_s;

        // R1: reset state
        do_reset();
        check("R1 state", cur_state, 1);
        check("R1 err", err_flag, 0);
        check("R1 enables", {mbx_en, pd_en, out_en, fw_dl_en}, 0);

        // R2 R3 R4 R7 R8 R9 R10 R11: every source state against every code
        for (int si = 0; si < 5; si++) begin
            for (int c = 0; c < 16; c++) begin
                do_reset();
                reach(srcs[si]);
                check("R2 path reached", cur_state, srcs[si]);
                request(4'(c), 1'b0);
                exp_s = ref_ok(srcs[si], 4'(c)) ? 4'(c) : srcs[si];
                check(ref_ok(srcs[si], 4'(c)) ? "R3 state" : "R4 state", cur_state, exp_s);
                check((4'(c) == srcs[si]) ? "R11 err" : "R4 err", err_flag,
                      ref_ok(srcs[si], 4'(c)) ? 0 : 1);
                check("R7 R8 R9 R10 enables", {mbx_en, pd_en, out_en, fw_dl_en}, ref_en(exp_s));
            end
        end

        // R6: idle strobe ignores req_state
        do_reset();
        reach(4'd4);
        req_state = 4'd8;
        repeat (2) @(negedge clk);
        check("R6 state", cur_state, 4);
        req_state = 4'd0;
        @(negedge clk);
        check("R6 err", err_flag, 0);

        // R5: sticky error, ack priority
        do_reset();
        pulse_ack();
        check("R5 ack without err", err_flag, 0);
        request(4'd8, 1'b0);
        check("R5 set", err_flag, 1);
        check("R5 state kept", cur_state, 1);
        request(4'd2, 1'b0);
        check("R5 sticky over legal move", err_flag, 1);
        check("R5 legal move taken", cur_state, 2);
        repeat (3) @(negedge clk);
        check("R5 held idle", err_flag, 1);
        request(4'd8, 1'b1);
        check("R5 reject beats ack", err_flag, 1);
        request(4'd4, 1'b1);
        check("R5 ack with legal request clears", err_flag, 0);
        check("R5 legal request with ack taken", cur_state, 4);
        request(4'd3, 1'b0);
        check("R5 set again", err_flag, 1);
        pulse_ack();
        check("R5 ack clears", err_flag, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule